// File: doc/BRIEF.md
# Dual-Channel Overtemperature Comparator with Hysteresis

This block watches two signed 8-bit temperature readings, one from a local sensor and one from a remote sensor. Each reading is compared with its own programmable overtemperature limit. Whenever either channel is in alarm, the block drives a shared active-low open-drain alarm pin. The block does not drive the pin level directly. It produces an enable: a 1 means pull the pin low, and a 0 means leave it to the external pull-up.

The two channels share one hysteresis value, held in two's-complement form. A channel in alarm releases only when a new sample falls strictly below its limit minus that hysteresis. This difference is computed in signed arithmetic and clamped to the range -128 to +127.

Each channel also has a status flag. A flag sets together with its alarm latch. A status-read pulse clears a flag only if that channel's latch had already released before the read. A flag therefore survives any number of reads while its condition persists.

Top module: `ot_alarm_top`

## Requirements
- R1: While reset is asserted, both alarm latches, both status bits and the pin enable are 0.
- R2: On a cycle with the valid strobe high, a channel whose signed temperature is strictly greater than its signed limit has its alarm latch set at that clock edge. A temperature equal to the limit does not set the latch.
- R3: A channel in alarm releases on a valid sample whose temperature is strictly below (limit - hysteresis). A sample equal to that threshold keeps the alarm. Setting takes priority over release.
- R4: The release threshold is computed as signed 8-bit limit minus signed 8-bit hysteresis, saturated to -128 and +127. It is never computed with wrap-around.
- R5: The output pin_pull_o is 1 exactly when at least one channel latch is set.
- R6: Status bit 1 belongs to the remote channel and bit 0 to the local channel. Each bit becomes 1 at the same edge at which its latch sets.
- R7: A status read on a cycle where a channel latch is set leaves that channel's status bit at 1.
- R8: A status read clears a status bit at that edge only if its latch was already clear before the edge. Without a read, a status bit stays at 1 after its latch releases.
- R9: Cycles without the valid strobe leave both latches unchanged, whatever the temperature inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_valid_i | input | 1 | Both temperature inputs carry a new sample this cycle |
| local_temp_i | input | 8 | Local temperature, two's complement |
| remote_temp_i | input | 8 | Remote temperature, two's complement |
| local_limit_i | input | 8 | Local overtemperature limit, two's complement |
| remote_limit_i | input | 8 | Remote overtemperature limit, two's complement |
| hyst_i | input | 8 | Shared hysteresis, two's complement |
| status_rd_i | input | 1 | One-cycle status read pulse |
| pin_pull_o | output | 1 | 1 = pull the open-drain alarm pin low, 0 = release it |
| status_o | output | 2 | Overtemperature flags: bit 1 remote, bit 0 local |

## Verification
A latch stuck in the wrong state shows on pin_pull_o one cycle after the sample that should have moved it. A wrapped threshold instead of a saturated one shows only when a limit near the range end is paired with a large hysteresis; such a latch releases at the wrong temperature, or never releases. A status flag that clears too early or too late differs from the expected value one cycle after the read pulse. The bench therefore reads status while a latch is set, in the same cycle as a release, and after a release.

// File: rtl/ot_pkg.sv
package ot_pkg;
  localparam int unsigned NCH       = 2;
  localparam int unsigned CH_LOCAL  = 0;
  localparam int unsigned CH_REMOTE = 1;
endpackage

// File: rtl/ot_release_calc.sv
module ot_release_calc #(
  parameter int unsigned TW = 8
) (
  input  logic [TW-1:0] limit_i,
  input  logic [TW-1:0] hyst_i,
  output logic [TW-1:0] release_o
);
  logic [TW:0] diff;

  assign diff = {limit_i[TW-1], limit_i} - {hyst_i[TW-1], hyst_i};

  // clamp when the extra sign bit disagrees with the result sign
  always_comb begin
    if (diff[TW] != diff[TW-1]) begin
      release_o = diff[TW] ? {1'b1, {(TW-1){1'b0}}} : {1'b0, {(TW-1){1'b1}}};
    end else begin
      release_o = diff[TW-1:0];
    end
  end
endmodule

// File: rtl/ot_channel.sv
module ot_channel #(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [TW-1:0] temp_i,
  input  logic [TW-1:0] limit_i,
  input  logic [TW-1:0] release_i,
  input  logic          rd_i,
  output logic          alarm_o,
  output logic          status_o
);
  logic alarm_q, status_q;
  logic over, under;
  logic alarm_d, status_d;

  always_comb begin
    over     = valid_i && ($signed(temp_i) > $signed(limit_i));
    under    = valid_i && alarm_q && ($signed(temp_i) < $signed(release_i));
    alarm_d  = over | (alarm_q & ~under);
    // read clears only a flag whose latch was already released
    status_d = over | (status_q & ~(rd_i & ~alarm_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q  <= 1'b0;
      status_q <= 1'b0;
    end else begin
      alarm_q  <= alarm_d;
      status_q <= status_d;
    end
  end

  assign alarm_o  = alarm_q;
  assign status_o = status_q;
endmodule

// File: rtl/ot_alarm_top.sv
module ot_alarm_top
  import ot_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          temp_valid_i,
  input  logic [TW-1:0] local_temp_i,
  input  logic [TW-1:0] remote_temp_i,
  input  logic [TW-1:0] local_limit_i,
  input  logic [TW-1:0] remote_limit_i,
  input  logic [TW-1:0] hyst_i,
  input  logic          status_rd_i,
  output logic          pin_pull_o,
  output logic [NCH-1:0] status_o
);
  logic [TW-1:0]  temp_a  [NCH];
  logic [TW-1:0]  limit_a [NCH];
  logic [TW-1:0]  rel_a   [NCH];
  logic [NCH-1:0] alarm_q;

  assign temp_a[CH_LOCAL]   = local_temp_i;
  assign temp_a[CH_REMOTE]  = remote_temp_i;
  assign limit_a[CH_LOCAL]  = local_limit_i;
  assign limit_a[CH_REMOTE] = remote_limit_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ot_release_calc #(.TW(TW)) u_rel (
      .limit_i   (limit_a[c]),
      .hyst_i    (hyst_i),
      .release_o (rel_a[c])
    );

    ot_channel #(.TW(TW)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (temp_valid_i),
      .temp_i    (temp_a[c]),
      .limit_i   (limit_a[c]),
      .release_i (rel_a[c]),
      .rd_i      (status_rd_i),
      .alarm_o   (alarm_q[c]),
      .status_o  (status_o[c])
    );
  end

  assign pin_pull_o = |alarm_q;
endmodule

// File: rtl/ot_alarm_chk.sv
module ot_alarm_chk #(
  parameter int unsigned TW  = 8,
  parameter int unsigned NCH = 2
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           temp_valid_i,
  input logic [TW-1:0]  local_temp_i,
  input logic [TW-1:0]  remote_temp_i,
  input logic [TW-1:0]  local_limit_i,
  input logic [TW-1:0]  remote_limit_i,
  input logic           status_rd_i,
  input logic           pin_pull_o,
  input logic [NCH-1:0] status_o,
  input logic [NCH-1:0] alarm_i
);
  logic [NCH-1:0] set_c;
  assign set_c[0] = temp_valid_i && ($signed(local_temp_i) > $signed(local_limit_i));
  assign set_c[1] = temp_valid_i && ($signed(remote_temp_i) > $signed(remote_limit_i));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (status_o == '0 && !pin_pull_o);
    end
  end

  assert_pin_when_alarm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_i != '0) == pin_pull_o);

  assert_hold_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_valid_i |=> $stable(alarm_i));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    assert_set_on_over_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_c[c] |=> alarm_i[c]);

    assert_status_covers_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_i[c] |-> status_o[c]);

    assert_sticky_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_rd_i && alarm_i[c]) |=> status_o[c]);

    assert_clear_after_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_rd_i && !alarm_i[c] && !set_c[c]) |=> !status_o[c]);
  end
endmodule

bind ot_alarm_top ot_alarm_chk #(.TW(TW), .NCH(ot_pkg::NCH)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .temp_valid_i   (temp_valid_i),
  .local_temp_i   (local_temp_i),
  .remote_temp_i  (remote_temp_i),
  .local_limit_i  (local_limit_i),
  .remote_limit_i (remote_limit_i),
  .status_rd_i    (status_rd_i),
  .pin_pull_o     (pin_pull_o),
  .status_o       (status_o),
  .alarm_i        (alarm_q)
);

// File: tb/tb_ot_alarm_top.sv
module tb_ot_alarm_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       temp_valid_i = 1'b0;
  logic [7:0] local_temp_i = '0, remote_temp_i = '0;
  logic [7:0] local_limit_i = '0, remote_limit_i = '0, hyst_i = '0;
  logic       status_rd_i = 1'b0;
  logic       pin_pull_o;
  logic [1:0] status_o;

  int checks = 0;
  int fails = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference model state, bit 0 local, bit 1 remote
  logic [1:0] m_alarm = '0;
  logic [1:0] m_stat  = '0;

  always #2 clk_i = ~clk_i;

  ot_alarm_top dut (
    .clk_i, .rst_ni, .temp_valid_i, .local_temp_i, .remote_temp_i,
    .local_limit_i, .remote_limit_i, .hyst_i, .status_rd_i,
    .pin_pull_o, .status_o
  );

  function automatic int sx(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  function automatic int rel_of(input logic [7:0] lim, input logic [7:0] h);
    int r;
    r = sx(lim) - sx(h);
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic step(input string tag, input logic v, input int lt, input int rt,
                      input logic rd);
    logic [1:0] old_a;
    logic [1:0] over;
    logic [1:0] under;
    int t [2];
    int l [2];
    int r [2];
    @(negedge clk_i);
    temp_valid_i  = v;
    local_temp_i  = 8'(lt);
    remote_temp_i = 8'(rt);
    status_rd_i   = rd;
    t[0] = lt; t[1] = rt;
    l[0] = sx(local_limit_i); l[1] = sx(remote_limit_i);
    r[0] = rel_of(local_limit_i, hyst_i); r[1] = rel_of(remote_limit_i, hyst_i);
    old_a = m_alarm;
    for (int c = 0; c < 2; c++) begin
      over[c]  = v && (t[c] > l[c]);
      under[c] = v && old_a[c] && (t[c] < r[c]);
      m_alarm[c] = over[c] | (old_a[c] & ~under[c]);
      m_stat[c]  = over[c] | (m_stat[c] & ~(rd & ~old_a[c]));
    end
    exp_q.push_back({|m_alarm, m_stat});
    tag_q.push_back(tag);
  endtask

  // monitor: compare one item per clock, 1 ns after the edge
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [2:0] e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if ({pin_pull_o, status_o} !== e) begin
        fails++;
        $display("FAIL %s: pin/status got %b/%b expected %b/%b",
                 tg, pin_pull_o, status_o, e[2], e[1:0]);
      end
    end
  end

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    local_limit_i  = 8'd50;
    remote_limit_i = 8'd80;
    hyst_i         = 8'd5;
    #9;
    checks++;
    if (pin_pull_o !== 1'b0 || status_o !== 2'b00) begin
      fails++;
      $display("FAIL R1: reset pin/status got %b/%b expected 0/00", pin_pull_o, status_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    step("R2 equal to limit does not set", 1, 50, 80, 0);
    step("R2 R6 local over sets bit0", 1, 51, 0, 0);
    step("R7 read while latched keeps flag", 1, 51, 0, 1);
    step("R3 equal to release keeps alarm", 1, 45, 0, 0);
    step("R9 no valid no change", 0, -100, -100, 0);
    step("R3 below release clears", 1, 44, 0, 0);
    step("R8 flag stays without read", 0, 0, 0, 0);
    step("R8 read after release clears", 0, 0, 0, 1);
    step("R6 remote over sets bit1", 1, 0, 81, 0);
    step("R5 both channels latched", 1, 60, 81, 0);
    step("R5 remote released local held", 1, 60, 74, 0);
    step("R7 R8 read with same-cycle release", 1, 40, 0, 1);
    step("R8 second read clears", 0, 0, 0, 1);

    @(negedge clk_i);
    local_limit_i = 8'(-100);
    hyst_i        = 8'd100;
    step("R4 set at negative limit", 1, -99, 0, 0);
    step("R4 low saturation holds alarm", 1, -128, 0, 0);
    step("R4 low saturation holds on read", 1, -128, 0, 1);

    @(negedge clk_i);
    local_limit_i  = 8'd100;
    remote_limit_i = 8'd100;
    hyst_i         = 8'(-100);
    step("R4 high saturation local release remote set", 1, -128, 110, 0);
    step("R4 high saturation remote release", 1, -128, 100, 0);
    step("R8 final read clears", 0, 0, 0, 1);
    step("R9 idle", 0, 127, 127, 0);

    wait (exp_q.size() == 0);
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule